// File: doc/BRIEF.md
# NAND Block Erase Sequencer

This block erases one block of a raw x8 NAND flash device. A host gives a one-cycle start pulse together with a 24-bit row address. The block then drives the flash bus through the fixed erase transaction. It sends the erase setup opcode, then three row-address bytes with the low byte first, then the confirm opcode. It waits while the device reports busy and issues the status-read opcode. Finally it strobes the read-enable line once to fetch the status byte. Bit 0 of that byte decides whether the host sees pass or fail.

All flash timing is counted in system clock cycles through parameters: write-enable low and high widths, the delay before the busy line is trusted, the write-to-read turnaround and the read-enable low width. A watchdog counter bounds the busy wait. If the device is still busy after `TMO_CYC` cycles, the block skips the status read, releases chip enable and ends with fail set. The data bus is split into `io_out`, `io_oe` and `io_in`, so that the pad ring can build the bidirectional pin.

Top module: `nand_erase_seq`

## Requirements
- R1: While reset is held low, and straight after it, `ce_n`, `we_n` and `re_n` are 1, `cle`, `ale` and `io_oe` are 0, and `busy`, `done` and `fail` are 0.
- R2: A start in idle captures `row_addr`. The bytes latched on the rising edges of `we_n` are then 0x60 with `cle`=1 and `ale`=0, next `row_addr[7:0]`, `row_addr[15:8]` and `row_addr[23:16]` with `ale`=1 and `cle`=0, and then 0xD0 with `cle`=1. No column byte is sent.
- R3: Every `we_n` low pulse lasts exactly `T_WP` cycles, and `we_n` stays high for at least `T_WH` cycles between pulses.
- R4: After the 0xD0 cycle the block waits `T_WB` cycles and then waits for `rb_n` to be high after a two-flop synchroniser. It latches nothing while `rb_n` is low.
- R5: Once the device is ready, 0x70 is latched with `cle`=1. `re_n` falls no earlier than `T_WHR` cycles after the rising edge of `we_n` for that byte.
- R6: `re_n` is low for exactly `T_RP` cycles, once per transaction, with `io_oe`=0 throughout. The status is sampled in the last low cycle.
- R7: A status with bit 0 at 0 ends with `fail`=0, and a status with bit 0 at 1 ends with `fail`=1. Bits 7..1 have no effect.
- R8: `ce_n` goes low once per transaction, is low whenever `we_n` or `re_n` is low, and is high again by the cycle in which `done` is set.
- R9: If `rb_n` stays low for `TMO_CYC` cycles of the ready wait, no 0x70 is sent, `re_n` never falls, and the transaction ends with `done` and `fail`=1.
- R10: `busy` is 1 from the cycle after an accepted start until the end of the `done` cycle. `done` is a one-cycle pulse. `fail` is cleared on an accepted start and otherwise holds its value after `done`.
- R11: A start while busy is ignored: the running transaction keeps its captured address and a single `done` follows.
- R12: `cle` and `ale` are never high together, and `we_n` and `re_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to erase a block |
| row_addr | input | 24 | Row address of the block, low byte sent first |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| fail | output | 1 | Erase failed or the busy wait timed out |
| ce_n | output | 1 | Flash chip enable, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write enable, latches on its rising edge |
| re_n | output | 1 | Read enable, active low |
| io_out | output | 8 | Byte driven towards the flash |
| io_oe | output | 1 | Output enable for `io_out` |
| io_in | input | 8 | Byte read from the flash |
| rb_n | input | 1 | Ready/busy from the flash, low while busy |

## Verification
The bench sweeps status bytes whose upper bits disagree with bit 0. A design that decodes the wrong bit, or that samples before the status arrives, would report the wrong result, because the idle bus carries a value with bit 0 set. Busy times range from none at all to close to the timeout limit, plus one case past it. A design that leaves the wait early would latch 0x70 while `rb_n` is low, and one with a wrong limit would either hang or report a false failure. The bench also measures every `we_n` low width and the gap from the last write to `re_n`, so a miscounted timer shows up as a wrong pulse width or a short turnaround. A second start is injected mid-transaction with a different address; a design that accepted it would send the wrong row bytes or pulse `done` twice.

// File: rtl/nes_pkg.sv
package nes_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_WLO, S_WHI, S_TWB, S_RDY, S_TWHR, S_RLO, S_FIN
  } nes_state_e;

  localparam logic [7:0] OP_ERASE_SETUP = 8'h60;
  localparam logic [7:0] OP_ERASE_GO    = 8'hD0;
  localparam logic [7:0] OP_STATUS      = 8'h70;
  localparam logic [7:0] STAT_FAIL_MASK = 8'h01;

  // transaction slot numbers: order is the bus order
  localparam logic [2:0] SLOT_SETUP = 3'd0;
  localparam logic [2:0] SLOT_ROW0  = 3'd1;
  localparam logic [2:0] SLOT_ROW2  = 3'd3;
  localparam logic [2:0] SLOT_GO    = 3'd4;
  localparam logic [2:0] SLOT_STAT  = 3'd5;

  function automatic logic [7:0] slot_byte(input logic [2:0] slot, input logic [23:0] row);
    case (slot)
      3'd0:    return OP_ERASE_SETUP;
      3'd1:    return row[7:0];
      3'd2:    return row[15:8];
      3'd3:    return row[23:16];
      3'd4:    return OP_ERASE_GO;
      default: return OP_STATUS;
    endcase
  endfunction

  function automatic logic slot_is_addr(input logic [2:0] slot);
    return (slot >= SLOT_ROW0) && (slot <= SLOT_ROW2);
  endfunction

  function automatic logic status_failed(input logic [7:0] s);
    return |(s & STAT_FAIL_MASK);
  endfunction

  // cycles of extra wait after the write-high phase so that RE# falls
  // at least whr cycles after the WE# rise
  function automatic int unsigned whr_tail(input int unsigned whr, input int unsigned wh);
    return (whr > wh) ? (whr - wh) : 1;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/nes_phase_timer.sv
module nes_phase_timer #(
  parameter int unsigned LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [LW-1:0] len,
  output logic          expire
);
  logic [LW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= len - 1'b1;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expire = (cnt == '0);
endmodule

// File: rtl/nes_ready_watch.sv
module nes_ready_watch #(
  parameter int unsigned TMO_CYC = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rb_n,
  input  logic arm,
  output logic ready,
  output logic expired
);
  localparam int unsigned CW = $clog2(TMO_CYC + 1);

  logic          rb_s1, rb_s2;
  logic [CW-1:0] wait_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rb_s1 <= 1'b1;
      rb_s2 <= 1'b1;
    end else begin
      rb_s1 <= rb_n;
      rb_s2 <= rb_s1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !arm)                     wait_cnt <= '0;
    else if (wait_cnt != CW'(TMO_CYC - 1))  wait_cnt <= wait_cnt + 1'b1;
  end

  assign ready   = rb_s2;
  assign expired = arm && !rb_s2 && (wait_cnt == CW'(TMO_CYC - 1));
endmodule

// File: rtl/nand_erase_seq.sv
module nand_erase_seq
  import nes_pkg::*;
#(
  parameter int unsigned T_WP    = 2,
  parameter int unsigned T_WH    = 2,
  parameter int unsigned T_WB    = 4,
  parameter int unsigned T_WHR   = 6,
  parameter int unsigned T_RP    = 2,
  parameter int unsigned TMO_CYC = 100000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [23:0] row_addr,
  output logic        busy,
  output logic        done,
  output logic        fail,
  output logic        ce_n,
  output logic        cle,
  output logic        ale,
  output logic        we_n,
  output logic        re_n,
  output logic [7:0]  io_out,
  output logic        io_oe,
  input  logic [7:0]  io_in,
  input  logic        rb_n
);
  localparam int unsigned WHR_EXTRA = whr_tail(T_WHR, T_WH);
  localparam int unsigned LEN_MAX   = max2(max2(max2(T_WP, T_WH), max2(T_WB, T_RP)), WHR_EXTRA);
  localparam int unsigned LW        = $clog2(LEN_MAX + 1);

  nes_state_e    state, st_nx;
  logic [2:0]    slot;
  logic [23:0]   row_q;
  logic          fail_q;
  logic          t_exp, t_load;
  logic [LW-1:0] t_len;
  logic          rdy, tmo;

  // named events, used by the bound checker
  logic ev_accept, ev_stat_sample, ev_tmo;
  assign ev_accept      = (state == S_IDLE) && start;
  assign ev_stat_sample = (state == S_RLO) && t_exp;
  assign ev_tmo         = tmo;

  always_comb begin
    st_nx = state;
    unique case (state)
      S_IDLE: if (start) st_nx = S_WLO;
      S_WLO:  if (t_exp) st_nx = S_WHI;
      S_WHI:  if (t_exp) begin
                if (slot == SLOT_GO)        st_nx = S_TWB;
                else if (slot == SLOT_STAT) st_nx = S_TWHR;
                else                        st_nx = S_WLO;
              end
      S_TWB:  if (t_exp) st_nx = S_RDY;
      S_RDY:  if (rdy) st_nx = S_WLO;
              else if (tmo) st_nx = S_FIN;
      S_TWHR: if (t_exp) st_nx = S_RLO;
      S_RLO:  if (t_exp) st_nx = S_FIN;
      S_FIN:  st_nx = S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  always_comb begin
    unique case (st_nx)
      S_WLO:   t_len = LW'(T_WP);
      S_WHI:   t_len = LW'(T_WH);
      S_TWB:   t_len = LW'(T_WB);
      S_TWHR:  t_len = LW'(WHR_EXTRA);
      S_RLO:   t_len = LW'(T_RP);
      default: t_len = LW'(1);
    endcase
  end

  assign t_load = (st_nx != state);

  nes_phase_timer #(.LW(LW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .len(t_len), .expire(t_exp)
  );

  nes_ready_watch #(.TMO_CYC(TMO_CYC)) u_rdy (
    .clk(clk), .rst_n(rst_n), .rb_n(rb_n), .arm(state == S_RDY),
    .ready(rdy), .expired(tmo)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      slot   <= SLOT_SETUP;
      row_q  <= '0;
      fail_q <= 1'b0;
    end else begin
      state <= st_nx;
      if (ev_accept) begin
        slot   <= SLOT_SETUP;
        row_q  <= row_addr;
        fail_q <= 1'b0;
      end else if (state == S_WHI && t_exp && slot < SLOT_GO) begin
        slot <= slot + 1'b1;
      end else if (state == S_RDY && rdy) begin
        slot <= SLOT_STAT;
      end
      if (ev_stat_sample) fail_q <= status_failed(io_in);
      if (ev_tmo)         fail_q <= 1'b1;
    end
  end

  assign io_oe  = (state == S_WLO) || (state == S_WHI);
  assign cle    = io_oe && !slot_is_addr(slot);
  assign ale    = io_oe && slot_is_addr(slot);
  assign io_out = slot_byte(slot, row_q);
  assign we_n   = (state != S_WLO);
  assign re_n   = (state != S_RLO);
  assign ce_n   = (state == S_IDLE) || (state == S_FIN);
  assign busy   = (state != S_IDLE);
  assign done   = (state == S_FIN);
  assign fail   = fail_q;
endmodule

// File: rtl/nes_checker.sv
module nes_checker #(
  parameter int unsigned T_WHR = 6
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic fail,
  input logic ce_n,
  input logic cle,
  input logic ale,
  input logic we_n,
  input logic re_n,
  input logic io_oe,
  input logic stat_bit,
  input logic accept,
  input logic stat_sample,
  input logic tmo_hit
);
  localparam int unsigned CW = $clog2(T_WHR + 2);
  logic [CW-1:0] hi_run;

  always_ff @(posedge clk) begin
    if (!rst_n || !we_n)            hi_run <= '0;
    else if (hi_run < CW'(T_WHR))  hi_run <= hi_run + 1'b1;
  end

  p_strobe_ce_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n || !re_n) |-> !ce_n);
  p_read_hiz_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !re_n |-> !io_oe);
  p_latch_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));
  p_strobe_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n));
  p_whr_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(re_n) |-> (hi_run >= CW'(T_WHR)));
  p_status_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_sample |=> (fail == $past(stat_bit)));
  p_timeout_fail_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit |=> (done && fail));
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && !fail));
  p_ignore_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && start) |=> busy);
endmodule

bind nand_erase_seq nes_checker #(.T_WHR(T_WHR)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .fail(fail), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
  .re_n(re_n), .io_oe(io_oe), .stat_bit(io_in[0]), .accept(ev_accept),
  .stat_sample(ev_stat_sample), .tmo_hit(ev_tmo)
);

// File: tb/sim_nand_erase_seq.sv
`timescale 1ns/1ps
module sim_nand_erase_seq;
  localparam int P_WP = 2, P_WH = 2, P_WB = 3, P_WHR = 6, P_RP = 2, P_TMO = 64;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0, start = 1'b0;
  logic [23:0] row_addr = '0;
  logic        busy, done, fail, ce_n, cle, ale, we_n, re_n, io_oe;
  logic [7:0]  io_out;
  logic [7:0]  io_in = 8'hC3;
  logic        rb_n = 1'b1;

  nand_erase_seq #(.T_WP(P_WP), .T_WH(P_WH), .T_WB(P_WB), .T_WHR(P_WHR),
                   .T_RP(P_RP), .TMO_CYC(P_TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .row_addr(row_addr),
    .busy(busy), .done(done), .fail(fail), .ce_n(ce_n), .cle(cle),
    .ale(ale), .we_n(we_n), .re_n(re_n), .io_out(io_out), .io_oe(io_oe),
    .io_in(io_in), .rb_n(rb_n)
  );

  int n_run = 0, n_bad = 0, cyc = 0;

  // bus monitor and flash model state
  logic [7:0] lg_d [16];
  logic       lg_cle [16];
  logic       lg_ale [16];
  int nlg, we_lo, we_hi, wp_bad, wh_bad, since_we, last_whr, re_lo, re_cnt, rp_bad;
  int oe_bad, ce_bad, excl_bad, wr_busy, ce_falls, n_done, busy_left, bers_len;
  logic fail_at_done;
  logic [7:0] status_val;
  logic we_prev = 1'b1, re_prev = 1'b1, ce_prev = 1'b1;

  task automatic clear_mon();
    nlg = 0; we_lo = 0; we_hi = 100; wp_bad = 0; wh_bad = 0; since_we = 0;
    last_whr = -1; re_lo = 0; re_cnt = 0; rp_bad = 0; oe_bad = 0; ce_bad = 0;
    excl_bad = 0; wr_busy = 0; ce_falls = 0; n_done = 0; fail_at_done = 1'b0;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_run++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
    if (rst_n) begin
      if (re_prev && !re_n) last_whr = since_we;
      if (!we_n) we_lo++; else we_hi++;
      if (we_prev && !we_n) begin
        if (we_hi < P_WH) wh_bad++;
        we_hi = 0;
      end
      if (!we_prev && we_n) begin
        if (nlg < 16) begin
          lg_d[nlg] = io_out; lg_cle[nlg] = cle; lg_ale[nlg] = ale;
        end
        nlg++;
        if (we_lo != P_WP) wp_bad++;
        we_lo = 0;
        since_we = 1;
        if (!rb_n) wr_busy++;
        if (cle && io_out == 8'hD0 && bers_len > 0) busy_left = bers_len;
      end else if (we_n) since_we++;
      if (!re_n) re_lo++;
      if (!re_prev && re_n) begin
        re_cnt++;
        if (re_lo != P_RP) rp_bad++;
        re_lo = 0;
      end
      if (!re_n && io_oe) oe_bad++;
      if ((!we_n || !re_n) && ce_n) ce_bad++;
      if ((cle && ale) || (!we_n && !re_n)) excl_bad++;
      if (ce_prev && !ce_n) ce_falls++;
      if (done) begin n_done++; fail_at_done = fail; end
    end
    if (busy_left > 0) begin rb_n = 1'b0; busy_left--; end
    else rb_n = 1'b1;
    io_in = !re_n ? status_val : 8'hC3;
    we_prev = we_n; re_prev = re_n; ce_prev = ce_n;
  end

  function automatic logic [7:0] want_byte(input int i, input logic [23:0] r);
    logic [7:0] seq [6];
    seq = '{8'h60, r[7:0], r[15:8], r[23:16], 8'hD0, 8'h70};
    return seq[i];
  endfunction

  task automatic run_case(input logic [23:0] row, input int bers,
                          input logic [7:0] stat, input bit tmo_case, input bit intrude);
    logic exp_fail;
    int   exp_n, mism;
    exp_fail = tmo_case ? 1'b1 : stat[0];
    exp_n    = tmo_case ? 5 : 6;
    @(negedge clk); #1;
    clear_mon();
    row_addr = row; bers_len = bers; status_val = stat; start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0; row_addr = ~row;
    check(busy == 1'b1, "R10", "busy after start", busy, 1);
    if (intrude) begin
      repeat (6) @(negedge clk);
      #1; start = 1'b1; row_addr = 24'hABCDEF;
      @(negedge clk); #1; start = 1'b0;
    end
    for (int k = 0; k < 3000 && n_done == 0; k++) begin
      @(negedge clk); #1;
    end
    repeat (3) @(negedge clk);
    #1;
    check(n_done == 1, intrude ? "R11" : "R10", "done pulses", n_done, 1);
    check(fail_at_done == exp_fail, tmo_case ? "R9" : "R7", "fail at done", fail_at_done, exp_fail);
    check(fail == exp_fail, "R10", "fail held", fail, exp_fail);
    check(busy == 1'b0 && ce_n == 1'b1, "R8", "busy/ce_n after done", {busy, ce_n}, 2'b01);
    check(ce_falls == 1, "R8", "ce_n low periods", ce_falls, 1);
    check(nlg == exp_n, tmo_case ? "R9" : "R2", "latched bytes", nlg, exp_n);
    mism = 0;
    for (int i = 0; i < exp_n && i < nlg; i++) begin
      if (lg_d[i] != want_byte(i, row) || lg_ale[i] != (i >= 1 && i <= 3) ||
          lg_cle[i] != !(i >= 1 && i <= 3)) begin
        if (mism == 0)
          check(1'b0, (i == 5) ? "R5" : "R2", $sformatf("byte %0d {cle,ale,d}", i),
                {lg_cle[i], lg_ale[i], lg_d[i]},
                {!(i >= 1 && i <= 3), (i >= 1 && i <= 3), want_byte(i, row)});
        mism++;
      end
    end
    if (mism == 0) check(1'b1, "R2", "byte order", 0, 0);
    check(wp_bad == 0, "R3", "we_n low width errors", wp_bad, 0);
    check(wh_bad == 0, "R3", "we_n high width errors", wh_bad, 0);
    check(wr_busy == 0, "R4", "latches while rb_n low", wr_busy, 0);
    check(re_cnt == (tmo_case ? 0 : 1), tmo_case ? "R9" : "R6", "re_n pulses", re_cnt, tmo_case ? 0 : 1);
    check(rp_bad == 0 && oe_bad == 0, "R6", "re_n width/oe errors", {rp_bad, oe_bad}, 0);
    if (!tmo_case)
      check(last_whr >= P_WHR, "R5", "we_n rise to re_n fall", last_whr, P_WHR);
    check(ce_bad == 0, "R8", "strobe with ce_n high", ce_bad, 0);
    check(excl_bad == 0, "R12", "exclusive line errors", excl_bad, 0);
  endtask

  initial begin
    logic [7:0] stats [6];
    int         berss [6];
    stats = '{8'h00, 8'h01, 8'hFE, 8'hFF, 8'hE0, 8'h41};
    berss = '{0, 4, 17, 40, 9, 55};
    busy_left = 0; bers_len = 0; status_val = 8'h00;
    clear_mon();
    repeat (3) @(negedge clk);
    #1;
    check({ce_n, we_n, re_n, cle, ale, io_oe} == 6'b111000, "R1", "bus in reset",
          {ce_n, we_n, re_n, cle, ale, io_oe}, 6'b111000);
    check({busy, done, fail} == 3'b000, "R1", "host in reset", {busy, done, fail}, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check({ce_n, we_n, re_n, busy} == 4'b1110, "R1", "after reset",
          {ce_n, we_n, re_n, busy}, 4'b1110);
    for (int i = 0; i < 6; i++)
      run_case(24'h13579B ^ (24'(i) * 24'h0A0B0C), berss[i], stats[i], 1'b0, 1'b0);
    run_case(24'h5AA5C3, 100, 8'h00, 1'b1, 1'b0);  // R9 timeout
    repeat (120) @(negedge clk);
    run_case(24'h000000, 12, 8'h00, 1'b0, 1'b0);   // pass after a timeout fail
    run_case(24'hFFFFFF, 20, 8'h01, 1'b0, 1'b1);   // R11 intruding start
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule